// File: doc/BRIEF.md
# Fine Phase Shift Step Controller

This block steers the fine phase adjustment port of an on-chip clock manager toward a phase that a host chooses. The host writes a signed target on its own data-interface clock. A second, free-running adjustment clock runs the stepping logic. That logic keeps a local shadow of the clock manager's phase position, counted in units of one 256th of the clock period. It issues single increment or decrement requests until the shadow equals the target.

Each request is a one-cycle enable with a direction bit. The block then waits for the clock manager's one-cycle completion pulse before it moves the shadow and compares again. The target crosses into the adjustment domain through a toggle handshake that holds the data stable. The shadow crosses back the same way, so the host can read it. Activity and a timeout error are brought back to the host as synchronized flags.

Top module: `fine_phase_ctrl`

## Requirements
- R1: A host write stores the value saturated to the range -LIM..+LIM (LIM=255 by default, 9-bit signed), and `target_o` shows it one host clock after the write.
- R2: After any write, `cur_phase_o` settles to the saturated target and `busy_o` then falls to 0.
- R3: `ps_en_o` is high for exactly one adjustment clock per request. No new request is issued before the completion pulse of the previous one has arrived.
- R4: `ps_inc_o` is 1 (increment) when the target is above the shadow and 0 (decrement) when it is below. Moving from one settled value to another takes exactly |difference| requests, all in one direction, and none when the two are equal.
- R5: The shadow changes only on a completion pulse that answers an outstanding request, and by exactly one unit in the requested direction. At rest it equals the number of increments minus the number of decrements since reset.
- R6: `busy_o` is 1 from the host clock after a write until the new target has been reached and reported on `cur_phase_o`.
- R7: A target written while a request is outstanding does not cut that request short. Later comparisons use the newest target, and the shadow ends on it.
- R8: If no completion pulse arrives within TMO adjustment clocks of a request (TMO=1024 by default), `err_o` becomes 1 and stays 1 until reset. It never sets while completions arrive in time.
- R9: While `rst_ni` is low, the target, shadow, `cur_phase_o`, `busy_o`, `err_o` and `ps_en_o` are all 0, and any outstanding request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Host data-interface clock |
| pclk_i | input | 1 | Free-running phase adjustment clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wr_en_i | input | 1 | Host write strobe for the target |
| wr_data_i | input | WR_W | Signed target, saturated on write |
| target_o | output | PW | Stored (saturated) target, host domain |
| cur_phase_o | output | PW | Shadow phase as seen in the host domain |
| busy_o | output | 1 | Stepping or transfer in progress |
| err_o | output | 1 | Sticky completion timeout flag |
| ps_en_o | output | 1 | One-cycle step request |
| ps_inc_o | output | 1 | Step direction, 1 = increment |
| ps_done_i | input | 1 | One-cycle step completion |

## Verification
The bench builds the block with LIM=20, TMO=64, PW=9 and WR_W=12. The narrow limit lets a sweep walk every target from beyond the negative limit to beyond the positive one, and hit both saturation edges with full-scale 12-bit writes. All of that fits in a short run. A 64-cycle timeout lets a stalled completion trip the error flag quickly. The completion stub varies its reply latency, and a write is made while a slow step is still outstanding.

// File: rtl/fine_phase_pkg.sv
package fine_phase_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} step_st_e;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/tog_xfer.sv
// Toggle handshake: source data held stable until the destination acknowledges.
module tog_xfer #(
  parameter int W = 8
) (
  input  logic         s_clk_i,
  input  logic         d_clk_i,
  input  logic         rst_ni,
  input  logic         send_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic [W-1:0] data_o
);
  logic         req_q, ack_q, seen_q;
  logic [0:0]   req_s, ack_s;
  logic [W-1:0] hold_q, out_q;

  assign busy_o = req_q != ack_s[0];

  always_ff @(posedge s_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (send_i && !busy_o) begin
      req_q  <= ~req_q;
      hold_q <= data_i;
    end
  end

  sync2 #(.W(1)) u_req_sync (.clk_i(d_clk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s));

  always_ff @(posedge d_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ack_q  <= 1'b0;
      out_q  <= '0;
    end else begin
      if (req_s[0] != seen_q) begin
        seen_q <= req_s[0];
        out_q  <= hold_q;
      end
      ack_q <= seen_q; // one cycle late: lets dependent status settle first
    end
  end

  sync2 #(.W(1)) u_ack_sync (.clk_i(s_clk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

  assign data_o = out_q;
endmodule

// File: rtl/ps_step_fsm.sv
module ps_step_fsm
  import fine_phase_pkg::*;
#(
  parameter int PW  = 9,
  parameter int TMO = 1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [PW-1:0] target_i,
  input  logic                 done_i,
  output logic                 en_o,
  output logic                 inc_o,
  output logic signed [PW-1:0] shadow_o,
  output logic                 active_o,
  output logic                 err_o
);
  localparam int TW = $clog2(TMO + 1);

  step_st_e             st_q;
  logic signed [PW-1:0] shadow_q;
  logic                 en_q, inc_q, err_q;
  logic [TW-1:0]        tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      shadow_q <= '0;
      en_q     <= 1'b0;
      inc_q    <= 1'b0;
      err_q    <= 1'b0;
      tmr_q    <= '0;
    end else begin
      en_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (target_i != shadow_q) begin
          en_q  <= 1'b1;
          inc_q <= target_i > shadow_q;
          tmr_q <= '0;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_i) begin
            shadow_q <= inc_q ? shadow_q + PW'(1) : shadow_q - PW'(1);
            st_q     <= ST_IDLE;
          end else begin
            if (tmr_q != TW'(TMO)) tmr_q <= tmr_q + TW'(1);
            if (tmr_q == TW'(TMO - 1)) err_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign en_o     = en_q;
  assign inc_o    = inc_q;
  assign shadow_o = shadow_q;
  assign active_o = (st_q != ST_IDLE) || en_q;
  assign err_o    = err_q;
endmodule

// File: rtl/fine_phase_ctrl.sv
module fine_phase_ctrl #(
  parameter int PW   = 9,
  parameter int LIM  = 255,
  parameter int WR_W = 12,
  parameter int TMO  = 1024
) (
  input  logic                   hclk_i,
  input  logic                   pclk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic signed [WR_W-1:0] wr_data_i,
  output logic signed [PW-1:0]   target_o,
  output logic signed [PW-1:0]   cur_phase_o,
  output logic                   busy_o,
  output logic                   err_o,
  output logic                   ps_en_o,
  output logic                   ps_inc_o,
  input  logic                   ps_done_i
);
  localparam logic signed [WR_W-1:0] LIM_W = WR_W'(LIM);

  // host domain
  logic signed [WR_W-1:0] sat_w;
  logic signed [PW-1:0]   target_q;
  logic                   pend_q, t_busy;
  logic [1:0]             stat_s;

  always_comb begin
    if (wr_data_i > LIM_W)       sat_w = LIM_W;
    else if (wr_data_i < -LIM_W) sat_w = -LIM_W;
    else                         sat_w = wr_data_i;
  end

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      pend_q   <= 1'b0;
    end else if (wr_en_i) begin
      target_q <= sat_w[PW-1:0];
      pend_q   <= 1'b1;
    end else if (!t_busy) begin
      pend_q   <= 1'b0;
    end
  end

  // phase domain
  logic signed [PW-1:0] target_p, shadow_p, sent_q;
  logic                 active, step_err, s_busy, s_send, pbusy_q;

  tog_xfer #(.W(PW)) u_tgt_xfer (
    .s_clk_i(hclk_i), .d_clk_i(pclk_i), .rst_ni(rst_ni),
    .send_i(pend_q), .data_i(target_q), .busy_o(t_busy), .data_o(target_p)
  );

  ps_step_fsm #(.PW(PW), .TMO(TMO)) u_fsm (
    .clk_i(pclk_i), .rst_ni(rst_ni), .target_i(target_p), .done_i(ps_done_i),
    .en_o(ps_en_o), .inc_o(ps_inc_o), .shadow_o(shadow_p),
    .active_o(active), .err_o(step_err)
  );

  assign s_send = (shadow_p != sent_q) && !s_busy;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q  <= '0;
      pbusy_q <= 1'b0;
    end else begin
      if (s_send) sent_q <= shadow_p;
      pbusy_q <= active || (shadow_p != target_p) || (shadow_p != sent_q) || s_busy;
    end
  end

  tog_xfer #(.W(PW)) u_shd_xfer (
    .s_clk_i(pclk_i), .d_clk_i(hclk_i), .rst_ni(rst_ni),
    .send_i(s_send), .data_i(shadow_p), .busy_o(s_busy), .data_o(cur_phase_o)
  );

  sync2 #(.W(2)) u_stat_sync (
    .clk_i(hclk_i), .rst_ni(rst_ni), .d_i({step_err, pbusy_q}), .q_o(stat_s)
  );

  assign target_o = target_q;
  assign busy_o   = pend_q || t_busy || stat_s[0];
  assign err_o    = stat_s[1];
endmodule

// File: rtl/fine_phase_ctrl_chk.sv
module fine_phase_ctrl_chk #(
  parameter int PW  = 9,
  parameter int LIM = 255
) (
  input logic                 hclk_i,
  input logic                 pclk_i,
  input logic                 rst_ni,
  input logic                 ps_en_o,
  input logic                 ps_inc_o,
  input logic                 ps_done_i,
  input logic signed [PW-1:0] shadow_p,
  input logic signed [PW-1:0] target_p,
  input logic signed [PW-1:0] target_o,
  input logic                 err_o
);
  localparam logic signed [PW-1:0] LIM_P = PW'(LIM);
  logic out_q;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni)        out_q <= 1'b0;
    else if (ps_en_o)   out_q <= 1'b1;
    else if (ps_done_i) out_q <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    ps_en_o |-> !out_q); // R3
  AST_EN_PULSE: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    ps_en_o |=> !ps_en_o); // R3
  AST_STEP_DIR: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    ps_en_o |-> ($past(target_p) != $past(shadow_p)) && (ps_inc_o == ($past(target_p) > $past(shadow_p)))); // R4
  AST_SHADOW_ON_DONE: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !$stable(shadow_p) |-> $past(ps_done_i && out_q)); // R5
  AST_SHADOW_RANGE: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    (shadow_p <= LIM_P) && (shadow_p >= -LIM_P)); // R5
  AST_TARGET_RANGE: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (target_o <= LIM_P) && (target_o >= -LIM_P)); // R1
  AST_ERR_STICKY: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
endmodule

bind fine_phase_ctrl fine_phase_ctrl_chk #(.PW(PW), .LIM(LIM)) u_chk (
  .hclk_i(hclk_i), .pclk_i(pclk_i), .rst_ni(rst_ni),
  .ps_en_o(ps_en_o), .ps_inc_o(ps_inc_o), .ps_done_i(ps_done_i),
  .shadow_p(shadow_p), .target_p(target_p), .target_o(target_o), .err_o(err_o)
);

// File: tb/fine_phase_ctrl_test.sv
`timescale 1ns/1ps
module fine_phase_ctrl_test;
  localparam int PW = 9, LIM = 20, WR_W = 12, TMO = 64;

  logic hclk = 1'b0, pclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, ps_done = 1'b0;
  logic signed [WR_W-1:0] wr_data = '0;
  logic signed [PW-1:0] target, cur_phase;
  logic busy, err, ps_en, ps_inc;

  always #10 hclk = ~hclk; // 50 MHz
  always #7  pclk = ~pclk;

  fine_phase_ctrl #(.PW(PW), .LIM(LIM), .WR_W(WR_W), .TMO(TMO)) uut (
    .hclk_i(hclk), .pclk_i(pclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .target_o(target),
    .cur_phase_o(cur_phase), .busy_o(busy), .err_o(err),
    .ps_en_o(ps_en), .ps_inc_o(ps_inc), .ps_done_i(ps_done)
  );

  int total = 0, bad = 0;
  int n_inc = 0, n_dec = 0, n_req = 0, model = 0;
  bit hold = 0, slow = 0, outst = 0, prev_en = 0, stub_dir = 0;
  int dly = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
  endfunction

  // clock manager stub
  initial forever begin
    @(negedge pclk);
    if (!rst_n) begin
      outst = 0; ps_done = 1'b0; prev_en = 0;
    end else begin
      ps_done = 1'b0;
      if (outst && !hold) begin
        if (dly == 0) begin
          ps_done = 1'b1; outst = 0;
          if (stub_dir) begin n_inc++; model++; end else begin n_dec++; model--; end
        end else dly--;
      end
      if (ps_en) begin
        if (prev_en) chk("R3 en width", 2, 1);
        if (outst)   chk("R3 overlap", 1, 0);
        outst = 1; stub_dir = ps_inc; n_req++;
        dly = slow ? 8 : (n_req % 4) + 1;
      end
      prev_en = ps_en;
    end
  end

  task automatic settle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge hclk);
    chk("R2 busy clears", int'(busy), 0);
  endtask

  task automatic write(input int v);
    @(negedge hclk);
    wr_en = 1'b1; wr_data = WR_W'(v);
    @(negedge hclk);
    wr_en = 1'b0;
    chk("R1 saturated target", int'(target), sat(v));
    chk("R6 busy after write", int'(busy), 1);
  endtask

  task automatic move(input int v);
    int prev, i0, d0;
    prev = int'(cur_phase); i0 = n_inc; d0 = n_dec;
    write(v);
    settle();
    chk("R2 cur_phase", int'(cur_phase), sat(v));
    chk("R5 stub model", model, sat(v));
    chk("R4 inc count", n_inc - i0, (sat(v) > prev) ? sat(v) - prev : 0);
    chk("R4 dec count", n_dec - d0, (sat(v) < prev) ? prev - sat(v) : 0);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge hclk);
    chk("R9 en in reset", int'(ps_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge hclk);
    chk("R9 target", int'(target), 0);
    chk("R9 cur_phase", int'(cur_phase), 0);
    chk("R9 busy", int'(busy), 0);
    chk("R9 err", int'(err), 0);

    for (int v = -(LIM + 3); v <= LIM + 3; v++) move(v);
    move(2047); move(-2048); move(LIM + 1); move(-(LIM + 1));
    move(0); move(0); move(LIM); move(-LIM); move(3);
    chk("R8 no false timeout", int'(err), 0);

    // R7: retarget while a slow step is outstanding
    move(0);
    slow = 1;
    begin
      int r0 = n_req;
      write(6);
      for (int i = 0; i < 500 && n_req == r0; i++) @(negedge pclk);
      write(-4);
    end
    settle();
    slow = 0;
    chk("R7 final phase", int'(cur_phase), -4);
    chk("R7 model", model, -4);
    chk("R7 net steps", n_inc - n_dec, -4);

    // R8: stalled completion
    hold = 1;
    write(-3);
    repeat (150) @(negedge hclk);
    chk("R8 err set", int'(err), 1);
    chk("R8 still busy", int'(busy), 1);
    hold = 0;
    settle();
    chk("R8 err sticky", int'(err), 1);
    chk("R2 after stall", int'(cur_phase), -3);

    // R9: reset mid-step drops request
    slow = 1;
    write(10);
    repeat (3) @(negedge hclk);
    rst_n = 1'b0;
    @(negedge hclk);
    chk("R9 en dropped", int'(ps_en), 0);
    chk("R9 target cleared", int'(target), 0);
    chk("R9 err cleared", int'(err), 0);
    chk("R9 busy cleared", int'(busy), 0);
    rst_n = 1'b1; slow = 0; model = 0;
    repeat (4) @(negedge hclk);
    chk("R9 phase cleared", int'(cur_phase), 0);
    move(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule